// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block orders the start-up and the over-current recovery of a multi-phase buck controller. It does no timing of its own. An external strobe marks each switching cycle, and the block counts those strobes through three phases. In the first phase every PWM output floats. In the second phase the outputs are pulled low, which clamps the lower switches. In the third phase normal PWM runs while a reference code climbs in a straight line from zero to the programmed target. A done flag rises on the last cycle of the sequence. That cycle comes later than the point where the output voltage would already have settled.

The block compares the averaged per-channel sense current against 165% of the full-scale value. When that trip fires, every output floats and the sequence starts again with a much longer first phase, so a hard short settles into a low-duty hiccup loop. Three other inputs take precedence over counting. The power-on-reset flag and the disable input stop everything. The latched over-voltage input takes control of the PWM mode and passes it to the monitor's clamp request. Every cycle count is a parameter, so short counts can be used in simulation.

Top module: `softstart_seq`

## Requirements
- R1: The PWM mode is encoded 2'b00 float, 2'b01 force-low and 2'b10 run. It is float during reset. From the clock after `porOk` is low or `shutdown` is high, the mode is float, `ssDone` is 0 and `refCode` is 0. When the sequence next starts, it uses the short first phase.
- R2: After a start, the first WAIT_START strobes keep the mode at float and `refCode` at 0.
- R3: The next CLAMP_CYC strobes hold the mode at force-low with `refCode` at 0.
- R4: After that the mode is run. Once m further strobes have arrived, `refCode` equals floor(targetCode·m / RAMP), where RAMP = DONE_CYC − WAIT_START − CLAMP_CYC. `refCode` never exceeds `targetCode`.
- R5: On the DONE_CYC-th strobe after a normal start, `ssDone` rises and `refCode` becomes `targetCode`. From then on it follows `targetCode` directly.
- R6: The over-current trip fires when senseAvg·20 > FULL_SCALE·33. With FULL_SCALE = 50, a value of 82 does not trip and a value of 83 does.
- R7: A trip in the force-low, ramp or done phase makes the mode float, `ssDone` 0 and `refCode` 0 from the next clock. The sequence then restarts with a first phase of WAIT_HICCUP strobes, followed by the force-low phase and the ramp.
- R8: A trip during a restarted ramp repeats the long-wait restart. A trip during the first phase has no effect on it.
- R9: From the clock after `ovLatch` is high, the sequencer is overridden. The mode is force-low while `ovClampReq` is 1 and float while it is 0. `ssDone` and `refCode` are 0. This override persists after `ovLatch` falls, until `porOk` drops or `shutdown` rises.
- R10: Without a strobe, the phase and `refCode` do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| porOk | input | 1 | Supply above power-on threshold |
| shutdown | input | 1 | Disable request, floats all outputs |
| cycStrobe | input | 1 | One pulse per switching cycle |
| senseAvg | input | SENSE_W | Averaged channel sense current code |
| ovLatch | input | 1 | Latched over-voltage from the monitor |
| ovClampReq | input | 1 | Monitor asks for the low clamp during over-voltage |
| targetCode | input | CODE_W | Programmed reference code |
| pwmMode | output | 2 | PWM mode for all phases |
| refCode | output | CODE_W | Ramping reference code |
| ssDone | output | 1 | Soft-start complete |

## Verification
The case that is hardest to reach from the ports is a second trip that lands inside a ramp which itself followed a trip. The bench reaches it in stages. It first completes a normal start. It then raises the sense input exactly across the 82/83 boundary, and while the long first phase runs it holds the sense value above the trip level, which must be ignored. It clears the over-current only before the last strobe of that phase. A trip is then applied two strobes into the new ramp, and the bench checks that the full long wait is counted again before the clamp returns.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [1:0] {
    PWM_TRI = 2'b00,
    PWM_LOW = 2'b01,
    PWM_RUN = 2'b10
  } pwm_mode_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_CLAMP, ST_RAMP, ST_DONE, ST_OVP
  } seq_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic longWait;
    logic rampOn;
    logic refFull;
  } seq_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic waitEnd;
    logic clampEnd;
    logic rampEnd;
    logic ocTrip;
  } seq_stat_t;

endpackage

// File: rtl/softstart_datapath.sv
module softstart_datapath
  import softstart_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SENSE_W     = 8,
  parameter int CNT_W       = 12,
  parameter int WAIT_START  = 32,
  parameter int WAIT_HICCUP = 2048,
  parameter int CLAMP_CYC   = 150,
  parameter int RAMP_CYC    = 1866,
  parameter int FULL_SCALE  = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_ctl_t           ctl,
  input  logic [SENSE_W-1:0] senseAvg,
  input  logic [CODE_W-1:0]  targetCode,
  output seq_stat_t          stat,
  output logic [CODE_W-1:0]  refCode
);

  localparam int PROD_W = CODE_W + CNT_W;
  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(WAIT_START);
  localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(WAIT_HICCUP);
  localparam logic [CNT_W-1:0] CLAMP_LEN = CNT_W'(CLAMP_CYC);
  localparam logic [CNT_W-1:0] RAMP_LEN  = CNT_W'(RAMP_CYC);
  localparam logic [31:0]      TRIP_LIM  = 32'(FULL_SCALE * 33);

  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  waitLen;
  logic [PROD_W-1:0] rampProd;
  logic [PROD_W-1:0] rampQuot;
  logic [31:0]       senseScaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseCnt <= '0;
    else if (ctl.cntClr) phaseCnt <= '0;
    else if (ctl.cntInc) phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    waitLen       = ctl.longWait ? LONG_LEN : SHORT_LEN;
    stat.waitEnd  = (phaseCnt == waitLen - 1'b1);
    stat.clampEnd = (phaseCnt == CLAMP_LEN - 1'b1);
    stat.rampEnd  = (phaseCnt == RAMP_LEN - 1'b1);
    // trip above 165 % of full scale: x*20 > fs*33
    senseScaled   = 32'(senseAvg) * 32'd20;
    stat.ocTrip   = (senseScaled > TRIP_LIM);
  end

  always_comb begin
    rampProd = PROD_W'(targetCode) * PROD_W'(phaseCnt);
    rampQuot = rampProd / PROD_W'(RAMP_CYC);
    if (ctl.refFull)     refCode = targetCode;
    else if (ctl.rampOn) refCode = rampQuot[CODE_W-1:0];
    else                 refCode = '0;
  end

  // R4
  ref_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    refCode <= targetCode);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cntInc && !ctl.cntClr) |=> $stable(phaseCnt));

endmodule

// File: rtl/softstart_ctrl.sv
module softstart_ctrl
  import softstart_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porOk,
  input  logic       shutdown,
  input  logic       cycStrobe,
  input  logic       ovLatch,
  input  logic       ovClampReq,
  input  seq_stat_t  stat,
  output seq_ctl_t   ctl,
  output logic [1:0] pwmMode,
  output logic       ssDone
);

  seq_state_e state, stateNxt;
  logic       hiccup, hiccupNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      hiccup <= 1'b0;
    end else begin
      state  <= stateNxt;
      hiccup <= hiccupNxt;
    end
  end

  always_comb begin
    stateNxt     = state;
    hiccupNxt    = hiccup;
    ctl.cntClr   = 1'b0;
    ctl.cntInc   = 1'b0;
    ctl.longWait = hiccup;
    ctl.rampOn   = (state == ST_RAMP);
    ctl.refFull  = (state == ST_DONE);
    if (!porOk || shutdown) begin
      stateNxt   = ST_OFF;
      hiccupNxt  = 1'b0;
      ctl.cntClr = 1'b1;
    end else if (ovLatch || state == ST_OVP) begin
      stateNxt   = ST_OVP;
      ctl.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          stateNxt   = ST_WAIT;
          ctl.cntClr = 1'b1;
        end
        ST_WAIT: begin
          if (cycStrobe) begin
            if (stat.waitEnd) begin
              stateNxt   = ST_CLAMP;
              ctl.cntClr = 1'b1;
            end else ctl.cntInc = 1'b1;
          end
        end
        ST_CLAMP, ST_RAMP, ST_DONE: begin
          if (stat.ocTrip) begin
            stateNxt   = ST_WAIT;
            hiccupNxt  = 1'b1;
            ctl.cntClr = 1'b1;
          end else if (cycStrobe && state == ST_CLAMP) begin
            if (stat.clampEnd) begin
              stateNxt   = ST_RAMP;
              ctl.cntClr = 1'b1;
            end else ctl.cntInc = 1'b1;
          end else if (cycStrobe && state == ST_RAMP) begin
            if (stat.rampEnd) begin
              stateNxt   = ST_DONE;
              ctl.cntClr = 1'b1;
            end else ctl.cntInc = 1'b1;
          end
        end
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_CLAMP:         pwmMode = PWM_LOW;
      ST_RAMP, ST_DONE: pwmMode = PWM_RUN;
      ST_OVP:           pwmMode = ovClampReq ? PWM_LOW : PWM_TRI;
      default:          pwmMode = PWM_TRI;
    endcase
    ssDone = (state == ST_DONE);
  end

  // R1
  off_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!porOk || shutdown) |=> (pwmMode == PWM_TRI && !ssDone));

  // R7
  oc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (porOk && !shutdown && !ovLatch && stat.ocTrip &&
     (state == ST_CLAMP || state == ST_RAMP || state == ST_DONE))
    |=> (state == ST_WAIT && hiccup));

  // R9
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (porOk && !shutdown && state == ST_OVP) |=> (state == ST_OVP));

  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssDone) |-> $past(cycStrobe));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SENSE_W     = 8,
  parameter int WAIT_START  = 32,
  parameter int WAIT_HICCUP = 2048,
  parameter int CLAMP_CYC   = 150,
  parameter int DONE_CYC    = 2048,
  parameter int FULL_SCALE  = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               porOk,
  input  logic               shutdown,
  input  logic               cycStrobe,
  input  logic [SENSE_W-1:0] senseAvg,
  input  logic               ovLatch,
  input  logic               ovClampReq,
  input  logic [CODE_W-1:0]  targetCode,
  output logic [1:0]         pwmMode,
  output logic [CODE_W-1:0]  refCode,
  output logic               ssDone
);

  localparam int RAMP_CYC = DONE_CYC - WAIT_START - CLAMP_CYC;
  localparam int MAX_A    = (WAIT_HICCUP > CLAMP_CYC) ? WAIT_HICCUP : CLAMP_CYC;
  localparam int MAX_LEN  = (MAX_A > RAMP_CYC) ? MAX_A : RAMP_CYC;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  seq_ctl_t  ctl;
  seq_stat_t stat;

  softstart_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .porOk      (porOk),
    .shutdown   (shutdown),
    .cycStrobe  (cycStrobe),
    .ovLatch    (ovLatch),
    .ovClampReq (ovClampReq),
    .stat       (stat),
    .ctl        (ctl),
    .pwmMode    (pwmMode),
    .ssDone     (ssDone)
  );

  softstart_datapath #(
    .CODE_W      (CODE_W),
    .SENSE_W     (SENSE_W),
    .CNT_W       (CNT_W),
    .WAIT_START  (WAIT_START),
    .WAIT_HICCUP (WAIT_HICCUP),
    .CLAMP_CYC   (CLAMP_CYC),
    .RAMP_CYC    (RAMP_CYC),
    .FULL_SCALE  (FULL_SCALE)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .senseAvg   (senseAvg),
    .targetCode (targetCode),
    .stat       (stat),
    .refCode    (refCode)
  );

endmodule

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WS = 4, WH = 12, CL = 3, DN = 24;
  localparam int RP = DN - WS - CL;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       porOk = 1'b0, shutdown = 1'b0, cycStrobe = 1'b0;
  logic       ovLatch = 1'b0, ovClampReq = 1'b0;
  logic [7:0] senseAvg = '0, targetCode = 8'd200;
  logic [1:0] pwmMode;
  logic [7:0] refCode;
  logic       ssDone;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softstart_seq #(.WAIT_START(WS), .WAIT_HICCUP(WH), .CLAMP_CYC(CL),
                  .DONE_CYC(DN), .FULL_SCALE(50)) u_softstart_seq (
    .clk(clk), .rstN(rstN), .porOk(porOk), .shutdown(shutdown),
    .cycStrobe(cycStrobe), .senseAvg(senseAvg), .ovLatch(ovLatch),
    .ovClampReq(ovClampReq), .targetCode(targetCode), .pwmMode(pwmMode),
    .refCode(refCode), .ssDone(ssDone));

  task automatic chk(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic outs(string req, int mode, int ref_v, int done);
    chk({req, " mode"}, pwmMode, mode);
    chk({req, " ref"}, refCode, ref_v);
    chk({req, " done"}, ssDone, done);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cycStrobe = 1'b1;
      @(negedge clk) cycStrobe = 1'b0;
    end
  endtask

  task automatic t_reset();
    idle(2);
    outs("R1 reset", 0, 0, 0);
    rstN = 1'b1;
    idle(2);
    outs("R1 por low", 0, 0, 0);
  endtask

  task automatic t_startup();
    porOk = 1'b1;
    idle(1);
    strobe(WS - 1);
    outs("R2 first phase", 0, 0, 0);
    idle(5);
    outs("R10 no strobe in wait", 0, 0, 0);
    strobe(1);
    outs("R3 clamp entry", 1, 0, 0);
    strobe(CL - 1);
    outs("R3 clamp end", 1, 0, 0);
    strobe(1);
    outs("R4 ramp start", 2, 0, 0);
    strobe(5);
    outs("R4 ramp m5", 2, 200 * 5 / RP, 0);
    idle(3);
    outs("R10 ramp hold", 2, 200 * 5 / RP, 0);
    strobe(RP - 6);
    outs("R4 ramp last", 2, 200 * (RP - 1) / RP, 0);
    strobe(1);
    outs("R5 done", 2, 200, 1);
    targetCode = 8'd100;
    idle(1);
    outs("R5 follows target", 2, 100, 1);
  endtask

  task automatic t_trip();
    senseAvg = 8'd82;
    idle(2);
    outs("R6 82 no trip", 2, 100, 1);
    senseAvg = 8'd83;
    idle(1);
    outs("R6 R7 83 trips", 0, 0, 0);
    senseAvg = 8'd120;
    strobe(WH - 1);
    outs("R8 trip ignored in wait", 0, 0, 0);
    senseAvg = 8'd0;
    strobe(1);
    outs("R7 long wait over", 1, 0, 0);
    strobe(CL);
    outs("R7 ramp after hiccup", 2, 0, 0);
    strobe(2);
    outs("R7 ramp m2", 2, 100 * 2 / RP, 0);
    senseAvg = 8'd90;
    idle(1);
    outs("R8 second trip", 0, 0, 0);
    senseAvg = 8'd0;
    strobe(WH - 1);
    outs("R8 long wait again", 0, 0, 0);
    strobe(1);
    outs("R8 clamp again", 1, 0, 0);
  endtask

  task automatic t_disable();
    shutdown = 1'b1;
    idle(1);
    outs("R1 shutdown", 0, 0, 0);
    shutdown = 1'b0;
    idle(1);
    strobe(WS - 1);
    outs("R1 short wait", 0, 0, 0);
    strobe(1);
    outs("R1 short wait over", 1, 0, 0);
    strobe(CL + RP);
    outs("R5 done after restart", 2, 100, 1);
  endtask

  task automatic t_ov();
    ovLatch = 1'b1;
    ovClampReq = 1'b1;
    idle(1);
    outs("R9 clamp request", 1, 0, 0);
    ovClampReq = 1'b0;
    idle(1);
    outs("R9 float", 0, 0, 0);
    ovClampReq = 1'b1;
    ovLatch = 1'b0;
    idle(2);
    outs("R9 sticky", 1, 0, 0);
    strobe(DN + 2);
    outs("R9 no sequence", 1, 0, 0);
    porOk = 1'b0;
    idle(1);
    outs("R1 R9 por drop", 0, 0, 0);
    porOk = 1'b1;
    ovClampReq = 1'b0;
    idle(1);
    strobe(WS);
    outs("R9 released", 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_trip();
    t_disable();
    t_ov();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule